// File: doc/BRIEF.md
# Latched 4-to-16 Decoder / Demultiplexer

This block turns a binary select word into a one-of-sixteen output vector. The select path contains a transparent latch. While `le_i` is high, the decode follows `sel_i` with no delay. While `le_i` is low, the decode keeps showing the last select that was loaded. The storage is a flop that loads on each rising `clk_i` edge while `le_i` is high. A mux bypasses the flop while the latch is open, which makes the path transparent.

An active-low enable `en_ni` acts directly on the outputs and does not pass through the latch. When `en_ni` is high, every output is forced to its inactive level. This lets the block work as a 1-to-16 demultiplexer: `en_ni` carries a serial data bit, and the latched select chooses which output receives it. The same pin serves as a chip select when several instances decode a wider address. The `POLARITY` parameter chooses whether the selected output is driven low or high.

Top module: `ldec_latched_decoder`

## Requirements
- R1: While `le_i` is high, the active output index equals the current `sel_i`, read as an unsigned binary number with `sel_i[0]` as the LSB. The output changes in the same cycle as `sel_i`, with no clock edge needed.
- R2: While `le_i` is low, changes on `sel_i` leave `y_o` unchanged.
- R3: After `le_i` falls, the held select is the `sel_i` value sampled at the last rising `clk_i` edge while `le_i` was high. `sel_i` must be stable across that edge.
- R4: While `en_ni` is low, exactly one of the 16 outputs is active. That output is the one whose index equals the effective select.
- R5: While `en_ni` is high, all outputs are at their inactive level, whatever `sel_i` and `le_i` are.
- R6: `en_ni` is not latched. It takes effect in the same cycle even while `le_i` is low, and the held select is kept through a disabled period.
- R7: With `POLARITY` = POL_LOW (the default), the active level is 0 and the inactive level is 1. With POL_HIGH, the active level is 1 and the inactive level is 0.
- R8: In demultiplex use with POL_LOW, the addressed output equals `en_ni` and every other output stays at 1. With POL_HIGH, the addressed output equals the inverse of `en_ni`.
- R9: Asynchronous reset (`rst_ni` low) clears the held select to 0. With `le_i` low and `en_ni` low, output 0 is then the active one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that loads the select latch |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Binary select / address |
| le_i | input | 1 | Latch enable: high means transparent, low means hold |
| en_ni | input | 1 | Active-low output enable and demultiplex data |
| y_o | output | 16 | Decoded outputs, polarity set by `POLARITY` |

## Verification
The bench tries every select value with the latch open. This shows that the decode is exactly one-hot and that `sel_i[0]` is the LSB. A scripted sequence alternates open and closed latch phases while `sel_i` keeps changing. This separates a latch that holds from one that leaks, and a capture taken at the clock edge from one taken when `le_i` falls. Toggling `en_ni` with the latch closed, on two instances of opposite polarity, shows that the enable is not latched and that each variant sends the data bit to the addressed output with the right sense.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;

  localparam int unsigned SEL_W_DEF = 4;
endpackage

// File: rtl/ldec_sel_latch.sv
module ldec_sel_latch #(
  parameter int unsigned SEL_W = ldec_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             le_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (le_i) sel_q <= sel_i;
  end

  // transparent while open, held value otherwise
  assign sel_o = le_i ? sel_i : sel_q;

  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i)) |-> $stable(sel_o));

  a_r3_capture_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(le_i) && $past(rst_ni)) |-> (sel_o == $past(sel_i)));
endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
  parameter int unsigned SEL_W = ldec_pkg::SEL_W_DEF,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_dec
    assign hot_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/ldec_out_stage.sv
module ldec_out_stage #(
  parameter int unsigned  OUT_N    = 16,
  parameter ldec_pkg::pol_e POLARITY = ldec_pkg::POL_LOW
) (
  input  logic [OUT_N-1:0] hot_i,
  input  logic             en_ni,
  output logic [OUT_N-1:0] y_o
);
  logic [OUT_N-1:0] gated;

  assign gated = en_ni ? '0 : hot_i;

  if (POLARITY == ldec_pkg::POL_LOW) begin : g_pol_low
    assign y_o = ~gated;
  end else begin : g_pol_high
    assign y_o = gated;
  end
endmodule

// File: rtl/ldec_latched_decoder.sv
module ldec_latched_decoder #(
  parameter int unsigned    SEL_W    = ldec_pkg::SEL_W_DEF,
  parameter ldec_pkg::pol_e POLARITY = ldec_pkg::POL_LOW,
  localparam int unsigned   OUT_N    = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             le_i,
  input  logic             en_ni,
  output logic [OUT_N-1:0] y_o
);
  logic [SEL_W-1:0] sel_eff;
  logic [OUT_N-1:0] hot;
  logic [OUT_N-1:0] act;

  ldec_sel_latch #(.SEL_W(SEL_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .le_i   (le_i),
    .sel_o  (sel_eff)
  );

  ldec_onehot #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_eff),
    .hot_o (hot)
  );

  ldec_out_stage #(.OUT_N(OUT_N), .POLARITY(POLARITY)) u_out (
    .hot_i (hot),
    .en_ni (en_ni),
    .y_o   (y_o)
  );

  // output viewed as active-high, for the checks below
  assign act = (POLARITY == ldec_pkg::POL_LOW) ? ~y_o : y_o;

  a_r4_single_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> ($countones(act) == 1));

  a_r1_follow_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !en_ni) |-> act[sel_i]);

  a_r5_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (act == '0));

  a_r2_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i) && !en_ni && $past(!en_ni)) |-> $stable(y_o));
endmodule

// File: tb/ldec_latched_decoder_tb_top.sv
module ldec_latched_decoder_tb_top;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned OUT_N = 16;
  localparam int unsigned NONE  = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [SEL_W-1:0] sel = 4'd11;
  logic             le = 1'b0;
  logic             en_n = 1'b0;
  logic [OUT_N-1:0] y_lo, y_hi;
  int               n_run = 0, n_fail = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ldec_latched_decoder #(.SEL_W(SEL_W), .POLARITY(ldec_pkg::POL_LOW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .le_i(le), .en_ni(en_n), .y_o(y_lo));

  ldec_latched_decoder #(.SEL_W(SEL_W), .POLARITY(ldec_pkg::POL_HIGH)) dut_hi_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .le_i(le), .en_ni(en_n), .y_o(y_hi));

  typedef struct packed {
    logic [3:0] sel;
    logic       le;
    logic       en_n;
    logic [4:0] idx;   // expected active index, 16 = none
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd5,  1'b1, 1'b0, 5'd5,  4'd1},  // R1 open
    '{4'd9,  1'b1, 1'b0, 5'd9,  4'd1},  // R1 follows
    '{4'd3,  1'b0, 1'b0, 5'd9,  4'd2},  // R2 closed, sel moves
    '{4'd12, 1'b0, 1'b0, 5'd9,  4'd2},  // R2
    '{4'd12, 1'b0, 1'b1, 5'd16, 4'd6},  // R6 disable while held
    '{4'd12, 1'b0, 1'b0, 5'd9,  4'd6},  // R6 held value back
    '{4'd15, 1'b1, 1'b0, 5'd15, 4'd1},  // R1 top index
    '{4'd0,  1'b1, 1'b0, 5'd0,  4'd1},  // R1 bottom index
    '{4'd0,  1'b0, 1'b0, 5'd0,  4'd2},  // R2
    '{4'd7,  1'b1, 1'b1, 5'd16, 4'd5},  // R5 inhibit while open
    '{4'd7,  1'b0, 1'b0, 5'd7,  4'd3},  // R3 loaded while disabled
    '{4'd8,  1'b1, 1'b0, 5'd8,  4'd1}   // R1
  };

  function automatic string tag_of(logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [OUT_N-1:0] exp_y(int unsigned idx, bit act_low);
    logic [OUT_N-1:0] v;
    v = (idx < OUT_N) ? (OUT_N'(1) << idx) : '0;
    return act_low ? ~v : v;
  endfunction

  task automatic check(string req, logic [OUT_N-1:0] act, logic [OUT_N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] s, logic l, logic e);
    @(negedge clk);
    sel = s; le = l; en_n = e;
    #2;
  endtask

  initial begin
    // R9: asynchronous reset with latch closed
    #6;
    check("R9 low", y_lo, exp_y(0, 1'b1));
    check("R9 high", y_hi, exp_y(0, 1'b0));
    @(negedge clk);
    rst_ni = 1'b1;

    foreach (VECS[k]) begin
      step(VECS[k].sel, VECS[k].le, VECS[k].en_n);
      check(tag_of(VECS[k].req), y_lo, exp_y(VECS[k].idx, 1'b1));
      check({tag_of(VECS[k].req), " R7"}, y_hi, exp_y(VECS[k].idx, 1'b0));
    end

    // R4 / R7: exhaustive select with latch open
    for (int i = 0; i < 16; i++) begin
      step(4'(i), 1'b1, 1'b0);
      check("R4", y_lo, exp_y(i, 1'b1));
      check("R7", y_hi, exp_y(i, 1'b0));
    end

    // R3: le falls together with a new sel value
    step(4'd2, 1'b1, 1'b0);
    step(4'd13, 1'b0, 1'b0);
    check("R3", y_lo, exp_y(2, 1'b1));
    step(4'd13, 1'b0, 1'b0);
    check("R3 hold", y_lo, exp_y(2, 1'b1));

    // R8: demultiplex on address 6
    step(4'd6, 1'b1, 1'b0);
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 2; r++) begin
        step(4'd1, 1'b0, 1'(d));
        check("R8 low vec", y_lo, d ? exp_y(NONE, 1'b1) : exp_y(6, 1'b1));
        check("R8 low bit", {15'd0, y_lo[6]}, {15'd0, 1'(d)});
        check("R8 high bit", {15'd0, y_hi[6]}, {15'd0, ~1'(d)});
      end
    end

    // R5 with latch open and moving select
    step(4'd10, 1'b1, 1'b1);
    check("R5", y_lo, exp_y(NONE, 1'b1));
    check("R5", y_hi, exp_y(NONE, 1'b0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule